// File: doc/BRIEF.md
# I2C SCL Divider Calculation Engine

This block turns a functional clock frequency and a requested I2C clock frequency, both given in hertz, into two separate phase dividers for an SCL generator: one for the LOW phase and one for the HIGH phase. The dividers are sized so that the I2C minimum LOW and HIGH times for the selected speed class are met, and so that the SCL rate never exceeds the request. Leftover time is placed on LOW first, but LOW is capped so that a data line held for half of LOW stays inside the maximum data-hold window.

A caller drives the two rates and pulses `start`. The engine captures them and works through seven divisions on one shared bit-serial divider, which takes roughly 470 clock cycles. It then raises `done` for one cycle with the results valid. The phase dividers are given with the generator's implicit +1 already removed. A result that does not fit sets `err`.

Top module: `scl_div_calc`

## Requirements
- R1: A requested SCL rate above 400000 Hz is treated as 400000 Hz, and one below 1000 Hz is treated as 1000 Hz.
- R2: After clamping, a rate of 100000 Hz or less uses the standard limits: LOW at least 4700 ns, HIGH at least 4000 ns, data hold at most 3450 ns. Any higher rate uses the fast limits: 1300 ns, 600 ns and 900 ns. Both classes use a 50 ns hold margin, and the LOW ceiling is twice the data hold minus that margin.
- R3: The clock rate is converted to kHz rounding up, and the SCL rate to kHz rounding down. The total divider must be at least ceil(clk_khz / (8*scl_khz)).
- R4: The least LOW and HIGH dividers are each ceil(clk_khz*ns / 8000000). The LOW ceiling divider is floor(clk_khz*ceiling_ns / 8000000). If that ceiling is below the least LOW divider, it is raised to equal it.
- R5: When the least LOW plus least HIGH is greater than the least total, the two least values are used unchanged.
- R6: Otherwise the spare count is the least total minus that sum. LOW takes ceil(clk_khz*min_low_ns / (8*scl_khz*(min_low_ns+min_high_ns))). This is first limited to the LOW ceiling, then to least LOW plus spare. HIGH takes its least value plus the spare that LOW left over.
- R7: `div_low` and `div_high` equal the chosen LOW and HIGH dividers minus one.
- R8: If either value minus one is 0xFFFF or more (including a wrap below zero), `err` is 1 and both divider outputs read 0xFFFF. Otherwise `err` is 0 and neither output is 0xFFFF.
- R9: `done` is high for exactly one cycle per accepted request. The outputs take their new values in that cycle and hold them until the next `done`.
- R10: A `start` pulse while a computation is running is ignored. It neither changes that computation's result nor produces a second `done`.
- R11: A synchronous reset clears `div_low`, `div_high`, `err` and `done`, and aborts any computation in progress without a later `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; rates are captured when idle |
| clk_rate | input | 32 | Functional clock frequency in Hz |
| scl_rate | input | 32 | Requested SCL frequency in Hz |
| done | output | 1 | One-cycle completion strobe |
| div_low | output | 16 | LOW phase divider minus one |
| div_high | output | 16 | HIGH phase divider minus one |
| err | output | 1 | Result out of range |

## Verification
The bench aims at the corners where a wrong choice is visible in the divider values.
- The 100000 Hz and 100001 Hz requests sit on either side of the speed-class split. A design that compares the wrong way would show the other class's LOW and HIGH values.
- Requests of 2 MHz and 500 Hz expose a missing clamp. An unclamped 2 MHz request would match no 400 kHz result, and an unclamped 500 Hz request would divide by zero.
- A 1 MHz clock at 400 kHz takes the branch where the hold minimums win. A 2 MHz clock at 200 kHz has a LOW ceiling below the LOW minimum: without the raise, LOW would drop to zero, wrap and flag an error.
- A 4 GHz clock at 1 kHz and a zero clock must both raise `err` with all-ones outputs. A start pulse during a computation and a reset mid-run must leave no stray result and no extra `done`.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int RATE_W = 32;
    localparam int WIDE_W = 64;
    localparam int DIV_W  = 16;

    localparam int unsigned SCL_MIN_HZ     = 1000;
    localparam int unsigned SCL_MAX_HZ     = 400000;
    localparam int unsigned STD_LIMIT_HZ   = 100000;
    localparam int unsigned HOLD_MARGIN_NS = 50;
    localparam int unsigned HZ_PER_KHZ     = 1000;
    localparam int unsigned PHASE_TICKS    = 8;
    localparam int unsigned NS_SCALE       = 8000000;

    typedef logic [WIDE_W-1:0] wide_t;

    typedef struct packed {
        wide_t low_min_ns;
        wide_t high_min_ns;
        wide_t low_max_ns;
        wide_t period_min_ns;
    } limits_t;

    typedef enum logic [2:0] {
        STEP_CLK_KHZ,
        STEP_SCL_KHZ,
        STEP_TOTAL_MIN,
        STEP_LOW_MIN,
        STEP_HIGH_MIN,
        STEP_LOW_MAX,
        STEP_LOW_IDEAL
    } step_e;

    localparam step_e LAST_STEP = STEP_LOW_IDEAL;

    typedef struct packed {
        wide_t clk_khz;
        wide_t scl_khz;
        wide_t total_min;
        wide_t low_min;
        wide_t high_min;
        wide_t low_max;
        wide_t low_ideal;
    } quots_t;

    function automatic logic [RATE_W-1:0] clamp_scl(input logic [RATE_W-1:0] hz);
        if (hz > RATE_W'(SCL_MAX_HZ))      return RATE_W'(SCL_MAX_HZ);
        else if (hz < RATE_W'(SCL_MIN_HZ)) return RATE_W'(SCL_MIN_HZ);
        else                               return hz;
    endfunction

    function automatic limits_t mode_limits(input logic fast);
        limits_t l;
        wide_t   hold;
        l.low_min_ns    = fast ? wide_t'(1300) : wide_t'(4700);
        l.high_min_ns   = fast ? wide_t'(600)  : wide_t'(4000);
        hold            = fast ? wide_t'(900)  : wide_t'(3450);
        l.low_max_ns    = (hold << 1) - wide_t'(HOLD_MARGIN_NS);
        l.period_min_ns = l.low_min_ns + l.high_min_ns;
        return l;
    endfunction

    function automatic wide_t round_up_num(input wide_t n, input wide_t d);
        return n + d - wide_t'(1);
    endfunction

endpackage

// File: rtl/sdc_divider.sv
module sdc_divider #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem_q;
    logic [W-1:0]     acc_q;
    logic [W-1:0]     den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       shifted;
    logic             fits;

    always_comb begin
        shifted = {rem_q[W-1:0], acc_q[W-1]};
        fits    = shifted >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            acc_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                rem_q <= '0;
                acc_q <= num;
                den_q <= den;
                cnt_q <= CNT_W'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= fits ? (shifted - {1'b0, den_q}) : shifted;
                acc_q <= {acc_q[W-2:0], fits};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = acc_q;

    // Quotient strobe is a single cycle and always ends a busy run (R9)
    assert_div_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_div_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

endmodule

// File: rtl/sdc_sequencer.sv
module sdc_sequencer
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] clk_rate,
    input  logic [RATE_W-1:0] scl_rate,
    output logic              div_go,
    output wide_t             div_num,
    output wide_t             div_den,
    input  logic              div_busy,
    input  logic              div_done,
    input  wide_t             div_quot,
    output quots_t            res,
    output logic              calc_done
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

    state_e            state;
    step_e             step;
    logic [RATE_W-1:0] clk_q;
    logic [RATE_W-1:0] scl_q;
    logic              fast;
    limits_t           lim;
    wide_t             clk_w;
    wide_t             tick_den;
    wide_t             ideal_den;

    always_comb begin
        fast      = scl_q > RATE_W'(STD_LIMIT_HZ);
        lim       = mode_limits(fast);
        clk_w     = wide_t'(clk_q);
        tick_den  = res.scl_khz * wide_t'(PHASE_TICKS);
        ideal_den = tick_den * lim.period_min_ns;
        div_go    = (state == S_ISSUE);
        div_num   = '0;
        div_den   = wide_t'(1);
        case (step)
            STEP_CLK_KHZ: begin
                div_den = wide_t'(HZ_PER_KHZ);
                div_num = round_up_num(clk_w, div_den);
            end
            STEP_SCL_KHZ: begin
                div_den = wide_t'(HZ_PER_KHZ);
                div_num = wide_t'(scl_q);
            end
            STEP_TOTAL_MIN: begin
                div_den = tick_den;
                div_num = round_up_num(res.clk_khz, tick_den);
            end
            STEP_LOW_MIN: begin
                div_den = wide_t'(NS_SCALE);
                div_num = round_up_num(res.clk_khz * lim.low_min_ns, div_den);
            end
            STEP_HIGH_MIN: begin
                div_den = wide_t'(NS_SCALE);
                div_num = round_up_num(res.clk_khz * lim.high_min_ns, div_den);
            end
            STEP_LOW_MAX: begin
                div_den = wide_t'(NS_SCALE);
                div_num = res.clk_khz * lim.low_max_ns;
            end
            default: begin
                div_den = ideal_den;
                div_num = round_up_num(res.clk_khz * lim.low_min_ns, ideal_den);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            step      <= STEP_CLK_KHZ;
            clk_q     <= '0;
            scl_q     <= '0;
            res       <= '0;
            calc_done <= 1'b0;
        end else begin
            calc_done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    clk_q <= clk_rate;
                    scl_q <= clamp_scl(scl_rate);
                    step  <= STEP_CLK_KHZ;
                    state <= S_ISSUE;
                end
                S_ISSUE: state <= S_WAIT;
                default: if (div_done) begin
                    case (step)
                        STEP_CLK_KHZ:   res.clk_khz   <= div_quot;
                        STEP_SCL_KHZ:   res.scl_khz   <= div_quot;
                        STEP_TOTAL_MIN: res.total_min <= div_quot;
                        STEP_LOW_MIN:   res.low_min   <= div_quot;
                        STEP_HIGH_MIN:  res.high_min  <= div_quot;
                        STEP_LOW_MAX:   res.low_max   <= div_quot;
                        default:        res.low_ideal <= div_quot;
                    endcase
                    if (step == LAST_STEP) begin
                        state     <= S_IDLE;
                        calc_done <= 1'b1;
                    end else begin
                        step  <= step_e'(step + 3'd1);
                        state <= S_ISSUE;
                    end
                end
            endcase
        end
    end

    // Captured rates stay frozen while a request is running (R10)
    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> $stable(clk_q) && $stable(scl_q));
    // Working SCL rate always lies inside the supported band (R1)
    assert_scl_band_R1: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |-> (scl_q >= RATE_W'(SCL_MIN_HZ)) && (scl_q <= RATE_W'(SCL_MAX_HZ)));
    // The divider is only launched when it is free (R9)
    assert_go_when_free_R9: assert property (@(posedge clk) disable iff (rst)
        div_go |-> !div_busy);

endmodule

// File: rtl/sdc_combine.sv
module sdc_combine
    import scl_div_pkg::*;
(
    input  quots_t           res,
    output logic [DIV_W-1:0] low_out,
    output logic [DIV_W-1:0] high_out,
    output logic             bad
);
    localparam wide_t LIMIT = wide_t'({DIV_W{1'b1}});

    wide_t low_cap, spare, low_pick, low_sel, high_sel, low_m1, high_m1;

    always_comb begin
        low_cap  = (res.low_min > res.low_max) ? res.low_min : res.low_max;
        spare    = '0;
        low_pick = res.low_ideal;
        if (res.low_min + res.high_min > res.total_min) begin
            low_sel  = res.low_min;
            high_sel = res.high_min;
        end else begin
            spare = res.total_min - res.low_min - res.high_min;
            if (low_pick > low_cap)               low_pick = low_cap;
            if (low_pick > res.low_min + spare)   low_pick = res.low_min + spare;
            low_sel  = low_pick;
            high_sel = res.high_min + spare - (low_pick - res.low_min);
        end
        low_m1   = low_sel  - wide_t'(1);
        high_m1  = high_sel - wide_t'(1);
        bad      = (low_m1 >= LIMIT) || (high_m1 >= LIMIT);
        low_out  = bad ? {DIV_W{1'b1}} : low_m1[DIV_W-1:0];
        high_out = bad ? {DIV_W{1'b1}} : high_m1[DIV_W-1:0];
    end

endmodule

// File: rtl/scl_div_calc.sv
module scl_div_calc
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] clk_rate,
    input  logic [RATE_W-1:0] scl_rate,
    output logic              done,
    output logic [DIV_W-1:0]  div_low,
    output logic [DIV_W-1:0]  div_high,
    output logic              err
);
    logic             div_go, div_busy, div_done, calc_done, bad_c;
    wide_t            div_num, div_den, div_quot;
    quots_t           res;
    logic [DIV_W-1:0] low_c, high_c;

    sdc_sequencer u_seq (
        .clk(clk), .rst(rst), .start(start),
        .clk_rate(clk_rate), .scl_rate(scl_rate),
        .div_go(div_go), .div_num(div_num), .div_den(div_den),
        .div_busy(div_busy), .div_done(div_done), .div_quot(div_quot),
        .res(res), .calc_done(calc_done)
    );

    sdc_divider #(.W(WIDE_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quot(div_quot)
    );

    sdc_combine u_comb (
        .res(res), .low_out(low_c), .high_out(high_c), .bad(bad_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            div_low  <= '0;
            div_high <= '0;
            err      <= 1'b0;
        end else begin
            done <= calc_done;
            if (calc_done) begin
                div_low  <= low_c;
                div_high <= high_c;
                err      <= bad_c;
            end
        end
    end

    // Completion strobe lasts one cycle (R9)
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // Results move only together with the strobe (R9)
    assert_hold_results_R9: assert property (@(posedge clk) disable iff (rst)
        (div_low != $past(div_low) || div_high != $past(div_high) || err != $past(err)) |-> done);
    // A clean result never uses the all-ones code (R8)
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (div_low != '1) && (div_high != '1));
    // An error result reports all ones on both dividers (R8)
    assert_err_ones_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> (div_low == '1) && (div_high == '1));

endmodule

// File: tb/sim_scl_div_calc.sv
module sim_scl_div_calc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] clk_rate = '0;
    logic [31:0] scl_rate = '0;
    logic        done;
    logic [15:0] div_low, div_high;
    logic        err;

    int checks = 0;
    int errors = 0;

    scl_div_calc u0 (
        .clk(clk), .rst(rst), .start(start), .clk_rate(clk_rate), .scl_rate(scl_rate),
        .done(done), .div_low(div_low), .div_high(div_high), .err(err)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Requirement-level model: {err, low, high}
    function automatic logic [32:0] model(input longint unsigned cr, input longint unsigned sr);
        longint unsigned s, mlo, mhi, hold, mxns, tot, ck, sk, mt, ml, mh, mx, ex, id, lo, hi, d;
        logic e;
        s    = (sr > 400000) ? 400000 : ((sr < 1000) ? 1000 : sr);
        mlo  = (s > 100000) ? 1300 : 4700;
        mhi  = (s > 100000) ? 600  : 4000;
        hold = (s > 100000) ? 900  : 3450;
        mxns = 2 * hold - 50;
        tot  = mlo + mhi;
        ck   = (cr + 999) / 1000;
        sk   = s / 1000;
        mt   = (ck + sk * 8 - 1) / (sk * 8);
        ml   = (ck * mlo + 7999999) / 8000000;
        mh   = (ck * mhi + 7999999) / 8000000;
        mx   = (ck * mxns) / 8000000;
        if (ml > mx) mx = ml;
        if (ml + mh > mt) begin
            lo = ml; hi = mh;
        end else begin
            ex = mt - ml - mh;
            d  = sk * 8 * tot;
            id = (ck * mlo + d - 1) / d;
            if (id > mx) id = mx;
            if (id > ml + ex) id = ml + ex;
            lo = id;
            hi = mh + ex - (id - ml);
        end
        lo = lo - 1;
        hi = hi - 1;
        e  = (lo >= 65535) || (hi >= 65535);
        if (e) begin lo = 65535; hi = 65535; end
        return {e, lo[15:0], hi[15:0]};
    endfunction

    task automatic run_calc(input logic [31:0] cr, input logic [31:0] sr, output logic [32:0] got);
        int n;
        @(negedge clk);
        clk_rate = cr; scl_rate = sr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("R9 done seen", done, 1);
        got = {err, div_low, div_high};
        @(negedge clk);
        check("R9 done one cycle", done, 0);
        check("R9 outputs held", {err, div_low, div_high}, got);
    endtask

    task automatic run_case(input string req, input logic [31:0] cr, input logic [31:0] sr);
        logic [32:0] got, exp;
        run_calc(cr, sr, got);
        exp = model(cr, sr);
        check({req, " err"},      got[32],    exp[32]);
        check({req, " div_low"},  got[31:16], exp[31:16]);
        check({req, " div_high"}, got[15:0],  exp[15:0]);
    endtask

    task automatic test_reset_state();
        check("R11 reset done", done, 0);
        check("R11 reset err", err, 0);
        check("R11 reset dividers", {div_low, div_high}, 0);
    endtask

    task automatic test_clamp();
        logic [32:0] a, b;
        run_calc(32'd50_000_000, 32'd2_000_000, a);
        run_calc(32'd50_000_000, 32'd400_000, b);
        check("R1 high clamp matches 400k", a, b);
        run_calc(32'd50_000_000, 32'd500, a);
        run_calc(32'd50_000_000, 32'd1000, b);
        check("R1 low clamp matches 1k", a, b);
        check("R1 low clamp model", a, model(50_000_000, 1000));
    endtask

    task automatic test_busy_ignore();
        logic [32:0] exp;
        int n, extra;
        exp = model(24_000_000, 100_000);
        @(negedge clk);
        clk_rate = 32'd24_000_000; scl_rate = 32'd100_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        clk_rate = 32'd100_000_000; scl_rate = 32'd400_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("R10 first result kept", {err, div_low, div_high}, exp);
        extra = 0;
        repeat (800) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R10 no second done", extra, 0);
    endtask

    task automatic test_reset_abort();
        int extra;
        @(negedge clk);
        clk_rate = 32'd24_000_000; scl_rate = 32'd100_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 reset clears err", err, 0);
        check("R11 reset clears dividers", {div_low, div_high}, 0);
        rst = 1'b0;
        extra = 0;
        repeat (800) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R11 aborted run gives no done", extra, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset_state();
        rst = 1'b0;
        @(negedge clk);
        test_reset_state();
        run_case("R2 R3 R6 R7 standard 24M/100k", 32'd24_000_000, 32'd100_000);
        run_case("R2 fast just above split", 32'd24_000_000, 32'd100_001);
        run_case("R6 fast 100M/400k", 32'd100_000_000, 32'd400_000);
        run_case("R3 R6 odd clock 33.333M/250k", 32'd33_333_333, 32'd250_000);
        run_case("R5 hold branch 1M/400k", 32'd1_000_000, 32'd400_000);
        run_case("R4 ceiling raise 2M/200k", 32'd2_000_000, 32'd200_000);
        test_clamp();
        run_case("R8 overflow 4G/1k", 32'd4_000_000_000, 32'd1000);
        run_case("R8 zero clock wraps", 32'd0, 32'd100_000);
        test_busy_ignore();
        run_case("R8 error before reset", 32'd0, 32'd100_000);
        test_reset_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule